// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects level-sensitive interrupt lines and delivers them to up to four CPUs. The low interrupt numbers are private to each CPU: every CPU holds its own mask bit for each of them. Numbers 0 and 1 in that private range do not come from the shared source lines. Number 0 carries the CPU's inter-processor doorbell summary and number 1 carries its message-signalled doorbell summary. All higher numbers are shared sources. Each shared source has one global enable bit and a routing register that names the CPUs it may reach.

Software uses a single-cycle register port, and every access carries the index of the requesting CPU. Enables and masks are not written as bit vectors. Software writes an interrupt number to a dedicated set address or clear address. A CPU finds its work by reading its acknowledge register, which returns the lowest-numbered interrupt currently eligible for that CPU. Because all sources are levels, the read has no side effect: an interrupt stays pending until its line drops. A per-CPU output pin is high whenever that CPU has something eligible.

Top module: `mpic_core`

## Requirements
- R1: After reset every shared source is disabled, every private mask bit of every CPU is set, and every routing register reads zero. As a result, all acknowledge reads return 1023 and `irq_out` is all zero.
- R2: Writing number n (n > 28, n < NSRC) to offset 0x30 enables shared source n. Writing it to offset 0x34 disables it.
- R3: Writing number n (n <= 28) to offset 0x48 sets the mask of n for the writing CPU (`bus_cpu`) only. Writing it to offset 0x4C clears that mask. Masks of other CPUs do not change.
- R4: A private number (0..28) is eligible for a CPU when its line is high and that CPU's mask bit is clear; enable and routing have no effect on it. A shared number is eligible for CPU c when its line is high, its enable is set and routing bit c is set; masks have no effect on it.
- R5: The source register of number n is at offset 0x100 + 4n. Bits [3:0] hold the routing mask, where bit c selects CPU c. Bits [11:8] hold the stored per-CPU fast-interrupt enables. All other bits read as zero, and any address past the last source reads zero.
- R6: A read of offset 0x00 returns NSRC in bits [11:2] and zero elsewhere.
- R7: A read of offset 0x44 returns, in bits [9:0], the lowest-numbered interrupt eligible for the requesting CPU, or 1023 if there is none. All other bits are zero, and the read changes no state.
- R8: For CPU c, number 0 is driven by `ipi_sum[c]` and number 1 by `msi_sum[c]`. Bits 0 and 1 of `src_in` are ignored.
- R9: `irq_out[c]` is high exactly when some interrupt is eligible for CPU c. It follows inputs in the same cycle and register writes from the clock edge that stores them.
- R10: Enable, mask and routing writes that name a number at or above NSRC are ignored. Enable writes to private numbers are ignored, and mask writes to shared numbers are ignored.
- R11: Read data is presented on `bus_rdata` in the cycle after `bus_rd` is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Level interrupt lines, one per number |
| ipi_sum | input | NCPU | Per-CPU inter-processor doorbell summary (number 0) |
| msi_sum | input | NCPU | Per-CPU message-signalled doorbell summary (number 1) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_cpu | input | CPU_W | Index of the requesting CPU |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data; number-style writes use bits [9:0] |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NCPU | Per-CPU interrupt request |

## Verification
A write commits at the clock edge where it is sampled. Read data registers at that same edge, so an acknowledge read issued after a write already sees the new state. The bench drives each access on a falling edge and samples `bus_rdata` on the next falling edge, one edge after the read was taken. `irq_out` is combinational on the lines and stored state, so the bench samples it on a falling edge after any input or write has settled. Every expected value comes from a bench model of enables, masks and routes that is updated on each write.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int NUM_W       = 10;
  localparam int PRIV_LAST   = 28;
  localparam int PRIV_N      = PRIV_LAST + 1;
  localparam int NONE_NUM    = 1023;
  localparam int OFF_CTRL    = 'h000;
  localparam int OFF_EN_SET  = 'h030;
  localparam int OFF_EN_CLR  = 'h034;
  localparam int OFF_ACK     = 'h044;
  localparam int OFF_MSK_SET = 'h048;
  localparam int OFF_MSK_CLR = 'h04C;
  localparam int OFF_SRC     = 'h100;

  typedef enum logic [2:0] {
    OP_NONE, OP_EN_SET, OP_EN_CLR, OP_MSK_SET, OP_MSK_CLR, OP_SRC
  } wr_op_e;
endpackage

// File: rtl/mpic_regs.sv
module mpic_regs
  import mpic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [CPU_W-1:0]              bus_cpu,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [11:0]                   wdata,
  output logic [NSRC-1:0]               en_q,
  output logic [NCPU-1:0][PRIV_N-1:0]   mask_q,
  output logic [NSRC-1:0][3:0]          route_q,
  output logic [NSRC-1:0][3:0]          fiq_q
);
  localparam int SRC_END = OFF_SRC + 4 * NSRC;

  wr_op_e            op;
  logic [NUM_W-1:0]  num;
  logic [ADDR_W-1:0] src_off;
  logic [NUM_W-1:0]  src_idx;

  assign num     = wdata[NUM_W-1:0];
  assign src_off = bus_addr - ADDR_W'(OFF_SRC);
  assign src_idx = NUM_W'(src_off >> 2);

  always_comb begin
    op = OP_NONE;
    if (bus_wr) begin
      if (bus_addr == ADDR_W'(OFF_EN_SET))       op = OP_EN_SET;
      else if (bus_addr == ADDR_W'(OFF_EN_CLR))  op = OP_EN_CLR;
      else if (bus_addr == ADDR_W'(OFF_MSK_SET)) op = OP_MSK_SET;
      else if (bus_addr == ADDR_W'(OFF_MSK_CLR)) op = OP_MSK_CLR;
      else if (int'(bus_addr) >= OFF_SRC && int'(bus_addr) < SRC_END &&
               bus_addr[1:0] == 2'b00)           op = OP_SRC;
    end
  end

  // global enables: only shared numbers hold state
  for (genvar n = 0; n < NSRC; n++) begin : g_en
    if (n < PRIV_N) begin : g_priv
      assign en_q[n] = 1'b0;
    end else begin : g_shared
      always_ff @(posedge clk) begin
        if (!rst_n) en_q[n] <= 1'b0;
        else if (op == OP_EN_SET && num == NUM_W'(n)) en_q[n] <= 1'b1;
        else if (op == OP_EN_CLR && num == NUM_W'(n)) en_q[n] <= 1'b0;
      end
    end
  end

  // private masks: one bank per CPU
  for (genvar c = 0; c < NCPU; c++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[c] <= '1;
      end else if (bus_cpu == CPU_W'(c)) begin
        for (int n = 0; n < PRIV_N; n++) begin
          if (op == OP_MSK_SET && num == NUM_W'(n)) mask_q[c][n] <= 1'b1;
          else if (op == OP_MSK_CLR && num == NUM_W'(n)) mask_q[c][n] <= 1'b0;
        end
      end
    end
  end

  // per-source routing / fast enables
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= '0;
      fiq_q   <= '0;
    end else if (op == OP_SRC) begin
      for (int n = 0; n < NSRC; n++) begin
        if (src_idx == NUM_W'(n)) begin
          route_q[n] <= wdata[3:0];
          fiq_q[n]   <= wdata[11:8];
        end
      end
    end
  end
endmodule

// File: rtl/mpic_gate.sv
module mpic_gate
  import mpic_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NCPU = 4
) (
  input  logic [NSRC-1:0]               src_in,
  input  logic [NCPU-1:0]               ipi_sum,
  input  logic [NCPU-1:0]               msi_sum,
  input  logic [NSRC-1:0]               en_q,
  input  logic [NCPU-1:0][PRIV_N-1:0]   mask_q,
  input  logic [NSRC-1:0][3:0]          route_q,
  output logic [NCPU-1:0][NSRC-1:0]     elig
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar n = 0; n < NSRC; n++) begin : g_num
      if (n == 0) begin : g_ipi
        assign elig[c][n] = ipi_sum[c] & ~mask_q[c][n];
      end else if (n == 1) begin : g_msi
        assign elig[c][n] = msi_sum[c] & ~mask_q[c][n];
      end else if (n < PRIV_N) begin : g_priv
        assign elig[c][n] = src_in[n] & ~mask_q[c][n];
      end else begin : g_shared
        assign elig[c][n] = src_in[n] & en_q[n] & route_q[n][c];
      end
    end
  end
endmodule

// File: rtl/mpic_pick.sv
module mpic_pick #(
  parameter int W  = 64,
  parameter int IW = 10
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [NCPU-1:0]   ipi_sum,
  input  logic [NCPU-1:0]   msi_sum,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCPU-1:0]   irq_out
);
  localparam int SRC_END = OFF_SRC + 4 * NSRC;

  logic [NSRC-1:0]             en_q;
  logic [NCPU-1:0][PRIV_N-1:0] mask_q;
  logic [NSRC-1:0][3:0]        route_q;
  logic [NSRC-1:0][3:0]        fiq_q;
  logic [NCPU-1:0][NSRC-1:0]   elig;
  logic [NCPU-1:0]             hit;
  logic [NCPU-1:0][NUM_W-1:0]  top_num;
  logic [31:0]                 rd_val;
  logic [ADDR_W-1:0]           src_off;
  logic [NUM_W-1:0]            src_idx;

  wire unused_bits = ^{bus_wdata[31:12], src_in[1:0]};

  mpic_regs #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .wdata(bus_wdata[11:0]),
    .en_q(en_q), .mask_q(mask_q), .route_q(route_q), .fiq_q(fiq_q)
  );

  mpic_gate #(.NSRC(NSRC), .NCPU(NCPU)) u_gate (
    .src_in(src_in), .ipi_sum(ipi_sum), .msi_sum(msi_sum),
    .en_q(en_q), .mask_q(mask_q), .route_q(route_q), .elig(elig)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_pick
    mpic_pick #(.W(NSRC), .IW(NUM_W)) u_pick (
      .req(elig[c]), .hit(hit[c]), .idx(top_num[c])
    );
  end

  assign irq_out = hit;
  assign src_off = bus_addr - ADDR_W'(OFF_SRC);
  assign src_idx = NUM_W'(src_off >> 2);

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      rd_val[11:2] = NUM_W'(NSRC);
    end else if (bus_addr == ADDR_W'(OFF_ACK)) begin
      rd_val[NUM_W-1:0] = NUM_W'(NONE_NUM);
      for (int c = 0; c < NCPU; c++) begin
        if (bus_cpu == CPU_W'(c) && hit[c]) rd_val[NUM_W-1:0] = top_num[c];
      end
    end else if (int'(bus_addr) >= OFF_SRC && int'(bus_addr) < SRC_END &&
                 bus_addr[1:0] == 2'b00) begin
      for (int n = 0; n < NSRC; n++) begin
        if (src_idx == NUM_W'(n)) begin
          rd_val[3:0]  = route_q[n];
          rd_val[11:8] = fiq_q[n];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/mpic_core_chk.sv
module mpic_core_chk
  import mpic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int SRC_W = $clog2(NSRC)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [CPU_W-1:0]            bus_cpu,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NCPU-1:0]             irq_out,
  input logic [NSRC-1:0]             en_q,
  input logic [NCPU-1:0][PRIV_N-1:0] mask_q
);
  logic [NUM_W-1:0] num;
  logic [SRC_W-1:0] p_idx;
  logic [CPU_W-1:0] p_cpu;
  logic             cur_irq;
  logic             shared_num;
  logic             priv_num;

  assign num        = bus_wdata[NUM_W-1:0];
  assign shared_num = int'(num) >= PRIV_N && int'(num) < NSRC;
  assign priv_num   = int'(num) < PRIV_N;

  always_comb begin
    cur_irq = 1'b0;
    for (int c = 0; c < NCPU; c++) if (bus_cpu == CPU_W'(c)) cur_irq = irq_out[c];
  end

  always_ff @(posedge clk) begin
    p_idx <= SRC_W'(num);
    p_cpu <= bus_cpu;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> irq_out == '0);

  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_EN_SET) && shared_num) |=> en_q[p_idx]);

  a_r2_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_EN_CLR) && shared_num) |=> !en_q[p_idx]);

  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_MSK_SET) && priv_num) |=> mask_q[p_cpu][p_idx]);

  a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_MSK_CLR) && priv_num) |=> !mask_q[p_cpu][p_idx]);

  a_r6_count_field: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFF_CTRL)) |=> bus_rdata[11:2] == NUM_W'(NSRC));

  a_r7_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFF_ACK) && !cur_irq)
      |=> bus_rdata == 32'(NONE_NUM));

  a_r7_some_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFF_ACK) && cur_irq)
      |=> int'(bus_rdata) < NSRC);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !$past(!rst_n)) |=> $stable(bus_rdata));
endmodule

bind mpic_core mpic_core_chk #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .en_q(en_q), .mask_q(mask_q)
);

// File: tb/mpic_core_tb.sv
module mpic_core_tb;
  localparam int NSRC = 64;
  localparam int NCPU = 4;
  localparam int AW   = 12;
  localparam int PN   = 29;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic [NCPU-1:0] ipi_sum = '0;
  logic [NCPU-1:0] msi_sum = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [1:0]      bus_cpu = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCPU-1:0] irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit       m_en [NSRC];
  bit       m_mask [NCPU][PN];
  bit [3:0] m_route [NSRC];
  bit [3:0] m_fiq [NSRC];

  always #4 clk = ~clk;

  mpic_core #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .ipi_sum(ipi_sum), .msi_sum(msi_sum),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit elig(input int c, input int n);
    bit line;
    line = (n == 0) ? ipi_sum[c] : (n == 1) ? msi_sum[c] : src_in[n];
    if (n < PN) return line && !m_mask[c][n];
    return line && m_en[n] && m_route[n][c];
  endfunction

  function automatic int exp_ack(input int c);
    for (int n = 0; n < NSRC; n++) if (elig(c, n)) return n;
    return 1023;
  endfunction

  task automatic wr(input int a, input logic [31:0] d, input int c);
    int num;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_cpu = 2'(c);
    @(negedge clk);
    bus_wr = 1'b0;
    num = int'(d[9:0]);
    if (a == 'h30 && num >= PN && num < NSRC) m_en[num] = 1;
    if (a == 'h34 && num >= PN && num < NSRC) m_en[num] = 0;
    if (a == 'h48 && num < PN) m_mask[c][num] = 1;
    if (a == 'h4C && num < PN) m_mask[c][num] = 0;
    if (a >= 'h100 && a < 'h100 + 4 * NSRC && a % 4 == 0) begin
      m_route[(a - 'h100) / 4] = d[3:0];
      m_fiq[(a - 'h100) / 4]   = d[11:8];
    end
  endtask

  task automatic rd(input int a, input int c, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a); bus_cpu = 2'(c);
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int c = 0; c < NCPU; c++) begin
      rd('h44, c, v);
      chk({tag, " R7 ack"}, v, 32'(exp_ack(c)));
      chk({tag, " R9 irq_out"}, 32'(irq_out[c]), 32'(exp_ack(c) != 1023));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < NSRC; n++) begin m_en[n] = 0; m_route[n] = 0; m_fiq[n] = 0; end
    for (int c = 0; c < NCPU; c++) for (int n = 0; n < PN; n++) m_mask[c][n] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, all lines high still yields nothing
    src_in = '1; ipi_sum = '1; msi_sum = '1;
    @(negedge clk);
    chk("R1 irq_out after reset", 32'(irq_out), 0);
    for (int c = 0; c < NCPU; c++) begin
      rd('h44, c, v); chk("R1 ack after reset", v, 1023);
    end
    rd('h100 + 4 * 40, 0, v); chk("R1 route zero", v, 0);

    // R6: count field
    rd('h00, 2, v); chk("R6 control count", v, 32'(NSRC << 2));
    src_in = '0; ipi_sum = '0; msi_sum = '0;

    // R8: numbers 0/1 driven by summaries, src_in[1:0] ignored
    wr('h4C, 0, 3); wr('h4C, 1, 3);
    src_in[0] = 1'b1; src_in[1] = 1'b1;
    @(negedge clk);
    rd('h44, 3, v); chk("R8 src_in low bits ignored", v, 1023);
    msi_sum[3] = 1'b1;
    rd('h44, 3, v); chk("R8 msi summary is 1", v, 1);
    ipi_sum[3] = 1'b1;
    rd('h44, 3, v); chk("R8 ipi summary is 0", v, 0);
    rd('h44, 2, v); chk("R3 other cpu still masked", v, 1023);
    ipi_sum = '0; msi_sum = '0; src_in = '0;

    // R3/R4: private mask only affects writer
    src_in[5] = 1'b1;
    wr('h30, 5, 1); wr('h100 + 4 * 5, 32'h0, 1);
    wr('h4C, 5, 1);
    rd('h44, 1, v); chk("R4 private ignores enable/route", v, 5);
    rd('h44, 0, v); chk("R3 mask clear only for writer", v, 1023);
    wr('h48, 5, 1);
    rd('h44, 1, v); chk("R3 mask set", v, 1023);
    src_in = '0;

    // R2/R4/R5: shared source 40
    src_in[40] = 1'b1;
    wr('h100 + 4 * 40, 32'h0000_0A04, 0);
    rd('h100 + 4 * 40, 3, v); chk("R5 route readback", v, 32'h0000_0A04);
    rd('h44, 2, v); chk("R2 disabled shared", v, 1023);
    wr('h30, 40, 1);
    rd('h44, 2, v); chk("R2 enabled shared", v, 40);
    rd('h44, 0, v); chk("R4 unrouted cpu", v, 1023);
    wr('h48, 40, 2);
    rd('h44, 2, v); chk("R4 mask no effect on shared", v, 40);
    @(negedge clk);
    chk("R9 irq_out routed", 32'(irq_out), 32'b0100);
    // R10: out-of-range number aliasing 40 is ignored
    wr('h34, 40 + 64, 0);
    rd('h44, 2, v); chk("R10 out-of-range clear ignored", v, 40);
    rd('h100 + 4 * NSRC, 2, v); chk("R5 past last source reads zero", v, 0);
    // R7: lower shared wins, read has no side effect
    src_in[33] = 1'b1; wr('h30, 33, 0); wr('h100 + 4 * 33, 32'h4, 0);
    rd('h44, 2, v); chk("R7 lowest wins", v, 33);
    rd('h44, 2, v); chk("R7 read repeats", v, 33);
    src_in[33] = 1'b0;
    rd('h44, 2, v); chk("R7 level drop", v, 40);
    wr('h34, 40, 3);
    rd('h44, 2, v); chk("R2 disabled again", v, 1023);
    rd('h44, 2, v); chk("R11 rdata held", bus_rdata, 1023);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, num, c;
      op  = int'($urandom_range(0, 6));
      num = int'($urandom_range(0, 80));
      c   = int'($urandom_range(0, 3));
      case (op)
        0: wr('h30, 32'(num), c);
        1: wr('h34, 32'(num), c);
        2: wr('h48, 32'(num), c);
        3: wr('h4C, 32'(num), c);
        4: wr('h100 + 4 * (num % NSRC), $urandom & 32'h0000_0F0F, c);
        default: begin
          src_in  = {$urandom, $urandom} & {$urandom, $urandom};
          ipi_sum = 4'($urandom); msi_sum = 4'($urandom);
        end
      endcase
      if (it % 8 == 7) check_all("rand");
    end
    check_all("final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule